// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects up to 32 interrupt inputs and drives a single interrupt request line toward a processor. Each input has its own mode word, which holds a three-bit priority and a two-bit trigger selector, and its own 32-bit vector word. Software enables and disables inputs with write-one-to-act masks. It services an interrupt by reading the acknowledge register. That read returns the vector of the best qualifying input and raises the controller's current level to that input's priority. The level stays raised until an end-of-interrupt write.

Nesting is held on an in-service stack that is eight entries deep. An input can raise the request only when its priority is strictly above the level on top of the stack. Equal priorities are resolved toward the lower input number. An acknowledge read that finds nothing qualifying returns a spurious value that software can program. Such a read leaves the stack untouched.

The bus is a plain word-addressed strobe interface. Read data is registered and appears on the cycle after the read strobe. Only one strobe is active in any cycle.

Top module: `vpic`

## Requirements
- R1: After reset the request line is low, the enable mask reads 0, every mode word reads 0x20 (high level, priority 0), and an acknowledge read returns 0, which is the reset value of the spurious vector.
- R2: A write to the enable-set address (0x41) enables every input whose data bit is 1. A write to the enable-clear address (0x42) disables every input whose data bit is 1. Zero bits change nothing, and the enable mask reads back at 0x41.
- R3: With a level trigger, an input is pending exactly while it sits at the selected level. The selector codes are 2'b10 for high and 2'b00 for low, held in mode bits [5:4].
- R4: With an edge trigger, a pending bit is latched on the selected edge and stays set after the input returns. The selector codes are 2'b11 for rising and 2'b01 for falling.
- R5: The trigger selector is writable only for inputs marked in the TRIG_CFG mask (default inputs 0 and 25 to 31). All other inputs always read back 2'b10 in that field.
- R6: The request line and the acknowledge read pick the enabled pending input with the highest priority (mode bits [2:0]). On a tie, the lowest input number wins.
- R7: An acknowledge read at 0x40 returns the winner's vector word and pushes the winner's priority. From then on, only inputs with a strictly higher priority raise the request.
- R8: An acknowledge read with no qualifying input returns the spurious vector (0x45) and leaves the stack unchanged.
- R9: An acknowledge read clears the edge-pending bit of the input it selected.
- R10: A write to the edge-clear address (0x43) clears the latched edge-pending bit of every input whose data bit is 1. Zero bits change nothing.
- R11: Any write to the end-of-interrupt address (0x44) pops one stack level, and it has no effect on an empty stack. Eight such writes fully unwind an eight-deep stack.
- R12: Stack depth never exceeds eight, and a push onto a full stack is ignored.
- R13: Mode words live at 0x00 to 0x1F and vector words at 0x20 to 0x3F. Both read back what was written, subject to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Interrupt inputs |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data is valid the next cycle |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions take for granted that read and write strobes never coincide. The push and pop properties depend on this: they assume an acknowledge and an end-of-interrupt never land in the same cycle. The stimulus keeps within this by issuing each bus access as a single one-strobe cycle from its own task. The stimulus also changes inputs only at the falling clock edge and never while a strobe is active. As a result, edge latching never meets a clear or an acknowledge of the same input in the same cycle.

// File: rtl/vpic.sv
module vpic #(
  parameter int NSRC = 32,
  parameter int PRIO_W = 3,
  parameter int DEPTH = 8,
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [NSRC-1:0] TRIG_CFG = 32'hFE00_0001
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            bus_wr,
  input  logic            bus_rd,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_o
);
  localparam int SRC_W = $clog2(NSRC);
  localparam int LVL_W = PRIO_W + 1;
  localparam int DEP_W = $clog2(DEPTH + 1);
  localparam int STK_W = $clog2(DEPTH);
  localparam int TRIG_LSB = 4;
  localparam logic [1:0] TRIG_FIXED = 2'b10;
  localparam logic [AW-1:0] A_VEC  = AW'(NSRC);
  localparam logic [AW-1:0] A_IVR  = AW'(2 * NSRC);
  localparam logic [AW-1:0] A_EN   = AW'(2 * NSRC + 1);
  localparam logic [AW-1:0] A_DIS  = AW'(2 * NSRC + 2);
  localparam logic [AW-1:0] A_ECLR = AW'(2 * NSRC + 3);
  localparam logic [AW-1:0] A_EOI  = AW'(2 * NSRC + 4);
  localparam logic [AW-1:0] A_SPU  = AW'(2 * NSRC + 5);

  logic [PRIO_W-1:0] prio_q [NSRC];
  logic [1:0]        trig_q [NSRC];
  logic [DW-1:0]     vec_q  [NSRC];
  logic [PRIO_W-1:0] stk_q  [DEPTH];
  logic [DW-1:0]     spu_q;
  logic [NSRC-1:0]   en_q, edge_q, src_q;
  logic [DEP_W-1:0]  depth_q;

  logic [NSRC-1:0]   pend, qual, edge_hit, ack_mask, clr_mask;
  logic [DEP_W-1:0]  top_idx;
  logic [LVL_W-1:0]  cur_lvl;
  logic [SRC_W-1:0]  win_idx, sel;
  logic [PRIO_W-1:0] win_prio;
  logic              found, ack, eoi;

  assign sel     = bus_addr[SRC_W-1:0];
  assign ack     = bus_rd && bus_addr == A_IVR;
  assign eoi     = bus_wr && bus_addr == A_EOI;
  assign top_idx = depth_q - 1'b1;
  assign cur_lvl = (depth_q == '0) ? '0 : {1'b0, stk_q[top_idx[STK_W-1:0]]} + 1'b1;

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      pend[i]     = trig_q[i][0] ? edge_q[i] : (src_i[i] == trig_q[i][1]);
      edge_hit[i] = trig_q[i][0] &&
                    (trig_q[i][1] ? (src_i[i] & ~src_q[i]) : (~src_i[i] & src_q[i]));
      qual[i]     = en_q[i] && pend[i] && ({1'b0, prio_q[i]} + 1'b1 > cur_lvl);
    end
  end

  always_comb begin
    found = 1'b0;
    win_idx = '0;
    win_prio = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (qual[i] && (!found || prio_q[i] >= win_prio)) begin
        found = 1'b1;
        win_idx = SRC_W'(i);
        win_prio = prio_q[i];
      end
    end
  end

  assign irq_o    = found;
  assign ack_mask = (ack && found) ? (NSRC'(1) << win_idx) : '0;
  assign clr_mask = ack_mask | ((bus_wr && bus_addr == A_ECLR) ? bus_wdata[NSRC-1:0] : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        prio_q[i] <= '0;
        trig_q[i] <= TRIG_FIXED;
        vec_q[i]  <= '0;
      end
      for (int d = 0; d < DEPTH; d++) stk_q[d] <= '0;
      spu_q     <= '0;
      en_q      <= '0;
      edge_q    <= '0;
      src_q     <= '0;
      depth_q   <= '0;
      bus_rdata <= '0;
    end else begin
      src_q  <= src_i;
      edge_q <= (edge_q & ~clr_mask) | edge_hit;
      if (bus_wr) begin
        if (bus_addr < A_VEC) begin
          prio_q[sel] <= bus_wdata[PRIO_W-1:0];
          if (TRIG_CFG[sel]) trig_q[sel] <= bus_wdata[TRIG_LSB+1:TRIG_LSB];
        end else if (bus_addr < A_IVR) begin
          vec_q[sel] <= bus_wdata;
        end
        if (bus_addr == A_EN)  en_q <= en_q | bus_wdata[NSRC-1:0];
        if (bus_addr == A_DIS) en_q <= en_q & ~bus_wdata[NSRC-1:0];
        if (bus_addr == A_SPU) spu_q <= bus_wdata;
      end
      if (ack && found) begin
        if (depth_q < DEP_W'(DEPTH)) begin
          stk_q[depth_q[STK_W-1:0]] <= win_prio;
          depth_q <= depth_q + 1'b1;
        end
      end else if (eoi && depth_q != '0) begin
        depth_q <= depth_q - 1'b1;
      end
      if (bus_rd) begin
        if (bus_addr < A_VEC)
          bus_rdata <= DW'({trig_q[sel], {(TRIG_LSB - PRIO_W){1'b0}}, prio_q[sel]});
        else if (bus_addr < A_IVR) bus_rdata <= vec_q[sel];
        else if (ack)              bus_rdata <= found ? vec_q[win_idx] : spu_q;
        else if (bus_addr == A_EN) bus_rdata <= DW'(en_q);
        else if (bus_addr == A_SPU) bus_rdata <= spu_q;
        else bus_rdata <= '0;
      end
    end
  end

  a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= DEP_W'(DEPTH));
  a_r7_push: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_o && !bus_wr && depth_q < DEP_W'(DEPTH)) |=> depth_q == $past(depth_q) + 1'b1);
  a_r11_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !bus_rd && depth_q != '0) |=> depth_q == $past(depth_q) - 1'b1);
  a_r8_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq_o && !bus_wr) |=> (bus_rdata == $past(spu_q)) && $stable(depth_q));
  a_r2_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DIS) |=> (en_q & $past(bus_wdata[NSRC-1:0])) == '0);
endmodule

// File: tb/vpic_bench.sv
`timescale 1ns/1ps
module vpic_bench;
  localparam logic [31:0] CFG = 32'hFE00_0001;
  localparam logic [7:0] IVR = 8'h40, EN = 8'h41, DIS = 8'h42, ECLR = 8'h43, EOI = 8'h44, SPU = 8'h45;

  logic clk = 0, rst_n = 0, wr = 0, rd = 0, irq;
  logic [31:0] src = 0, wdata = 0, rdata;
  logic [7:0] addr = 0;
  int errors = 0, checks = 0;
  logic [31:0] r;

  always #2 clk = ~clk;

  vpic u_vpic (.clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr), .bus_wdata(wdata),
               .bus_wr(wr), .bus_rd(rd), .bus_rdata(rdata), .irq_o(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask
  task automatic bw(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask
  task automatic br(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1;
    @(negedge clk); rd = 0; d = rdata;
  endtask
  task automatic set_src(logic [31:0] v);
    @(negedge clk); src = v;
    @(negedge clk);
  endtask
  function automatic int pr(int i);
    return (i * 5 + 3) % 8;
  endfunction
  function automatic int win(logic [31:0] act);
    int w = -1;
    for (int i = 0; i < 32; i++)
      if (act[i] && (w < 0 || pr(i) > pr(w))) w = i;
    return w;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq", {31'b0, irq}, 0);
    br(EN, r); chk("R1 enables", r, 0);
    br(IVR, r); chk("R1 spurious", r, 0);
    br(8'd5, r); chk("R1 mode", r, 32'h20);

    // R2 write-one-to-act enable masks
    bw(EN, 32'hF0); br(EN, r); chk("R2 set", r, 32'hF0);
    bw(EN, 32'h0F); br(EN, r); chk("R2 set more", r, 32'hFF);
    bw(DIS, 32'h30); br(EN, r); chk("R2 clear", r, 32'hCF);
    bw(DIS, 0); bw(EN, 0); br(EN, r); chk("R2 zero bits", r, 32'hCF);
    bw(DIS, 32'hFFFF_FFFF);

    // R5 / R13 sweep over all mode and vector words
    for (int i = 0; i < 32; i++) begin
      bw(8'(i), 32'h10 | (i % 8));
      br(8'(i), r);
      chk("R5 trig field", r, (CFG[i] ? 32'h10 : 32'h20) | (i % 8));
      bw(8'(i), 32'h20 | pr(i));
      bw(8'(32 + i), 32'h100 + i);
      br(8'(32 + i), r); chk("R13 vector", r, 32'h100 + i);
    end
    bw(SPU, 32'h5A5A); br(SPU, r); chk("R13 spurious word", r, 32'h5A5A);

    // R6 / R7 / R8 pattern sweep, all level-high
    bw(EN, 32'hFFFF_FFFF);
    for (int k = 0; k < 48; k++) begin
      logic [31:0] pat;
      int w;
      pat = (k == 0) ? 32'h0 : (k < 33) ? (32'h1 << (k - 1)) | (32'h1 << ((k * 7) % 32))
                                        : (32'(k) * 32'h9E37_79B1) >> (k % 5);
      w = win(pat);
      set_src(pat);
      chk("R6 irq", {31'b0, irq}, {31'b0, pat != 0});
      br(IVR, r);
      chk("R6 winner vector", r, (w < 0) ? 32'h5A5A : 32'h100 + w);
      if (w >= 0) bw(EOI, 0);
    end
    bw(DIS, 32'hFFFF_FFFF);
    set_src(0);

    // R7 nesting
    bw(8'd3, 32'h22); bw(8'd10, 32'h25); bw(8'd4, 32'h22);
    bw(EN, 32'h418);
    set_src(32'h8);
    br(IVR, r); chk("R7 first ack", r, 32'h103);
    chk("R7 same level masked", {31'b0, irq}, 0);
    set_src(32'h408);
    chk("R7 higher raises", {31'b0, irq}, 1);
    br(IVR, r); chk("R7 nested ack", r, 32'h10A);
    set_src(32'h418);
    chk("R7 lower masked", {31'b0, irq}, 0);
    br(IVR, r); chk("R8 spurious while masked", r, 32'h5A5A);
    bw(EOI, 0);
    chk("R11 pop reopens", {31'b0, irq}, 1);
    br(IVR, r); chk("R7 re-ack", r, 32'h10A);
    bw(EOI, 0); bw(EOI, 0);
    br(IVR, r); chk("R6 after unwind", r, 32'h10A);
    bw(EOI, 0);
    bw(DIS, 32'hFFFF_FFFF); set_src(0);

    // R11 / R12 eight-deep stack
    bw(EOI, 0);
    for (int i = 0; i < 8; i++) bw(8'(i), 32'h20 | i);
    bw(EN, 32'hFF);
    for (int i = 0; i < 8; i++) begin
      set_src((32'h2 << i) - 1);
      br(IVR, r); chk("R11 push", r, 32'h100 + i);
    end
    br(IVR, r); chk("R12 full stack spurious", r, 32'h5A5A);
    set_src(32'h1);
    for (int i = 0; i < 7; i++) bw(EOI, 0);
    chk("R11 seven pops", {31'b0, irq}, 0);
    bw(EOI, 0);
    chk("R11 eighth pop", {31'b0, irq}, 1);
    bw(EOI, 0);
    chk("R11 empty pop no effect", {31'b0, irq}, 1);
    br(IVR, r); chk("R11 ack after unwind", r, 32'h100);
    bw(EOI, 0);
    bw(DIS, 32'hFFFF_FFFF); set_src(0);

    // R4 / R9 rising edge on input 0
    bw(8'd0, 32'h34); bw(EN, 32'h1);
    set_src(32'h1); chk("R4 rising latch", {31'b0, irq}, 1);
    set_src(32'h0); chk("R4 held after release", {31'b0, irq}, 1);
    br(IVR, r); chk("R4 edge vector", r, 32'h100);
    bw(EOI, 0);
    chk("R9 ack cleared edge", {31'b0, irq}, 0);
    bw(DIS, 32'h1);

    // R4 falling edge on input 26
    bw(8'd26, 32'h11); bw(EN, 32'h1 << 26);
    set_src(32'h1 << 26); chk("R4 falling ignores rise", {31'b0, irq}, 0);
    set_src(0); chk("R4 falling latch", {31'b0, irq}, 1);
    br(IVR, r); chk("R4 falling vector", r, 32'h11A);
    bw(EOI, 0); chk("R9 falling cleared", {31'b0, irq}, 0);
    bw(DIS, 32'h1 << 26);

    // R3 level low on 27, level high on 5
    bw(8'd27, 32'h01); bw(EN, 32'h1 << 27);
    set_src(0); chk("R3 low level active", {31'b0, irq}, 1);
    set_src(32'h1 << 27); chk("R3 low level inactive", {31'b0, irq}, 0);
    bw(DIS, 32'h1 << 27); set_src(0);
    bw(EN, 32'h20);
    set_src(32'h20); chk("R3 high level active", {31'b0, irq}, 1);
    set_src(0); chk("R3 high level released", {31'b0, irq}, 0);
    bw(DIS, 32'h20);

    // R10 edge clear command
    bw(8'd28, 32'h31);
    set_src(32'h1 << 28); set_src(0);
    bw(ECLR, 32'h1 << 28); bw(EN, 32'h1 << 28);
    chk("R10 cleared edge", {31'b0, irq}, 0);
    bw(DIS, 32'h1 << 28);
    set_src(32'h1 << 28); set_src(0);
    bw(ECLR, ~(32'h1 << 28)); bw(EN, 32'h1 << 28);
    chk("R10 zero bit keeps edge", {31'b0, irq}, 1);
    br(IVR, r); chk("R10 vector", r, 32'h11C);
    bw(EOI, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule